// File: doc/BRIEF.md
# Reciprocal Gated Frequency Counter

This block measures the frequency of two square-wave inputs by reciprocal counting. A start pulse arms every channel. Each channel then waits for the first falling edge of its input. That edge opens a gate of fixed length, counted in sample ticks. During the gate the channel counts each further falling edge. On every counted edge it also stores the number of ticks elapsed since the opening edge. When the gate closes, the channel presents the edge count and the time of the last counted edge. A downstream divider forms the frequency as scale × count / time. The error is therefore a fixed fraction of the reading across the whole input range, instead of a fixed number of hertz.

The sample tick is a single-clock enable supplied by the surrounding logic. It sets the time quantum, and the inputs are examined only on ticks. Each raw input passes through a two-flop synchronizer before it is examined. Every channel runs its own state machine:

- Idle until the first start.
- Arming: waits for the first falling edge.
- Gating: counts edges until the gate closes.
- Done: holds the results.

The transitions are named as follows:

- **arm**: a start pulse from any state goes to Arming.
- **open**: a falling edge seen while Arming goes to Gating.
- **timeout**: the arming window expires with no edge, going from Arming to Done.
- **close**: the gate rolls over, going from Gating to Done.

Top module: `recip_freq_counter`

## Requirements
- R1: A start pulse (arm) puts a channel into Arming from any state and clears its count, time and overflow flag. While Arming the count stays zero. The falling edge that causes open clears the gate timer and the timestamp, and that edge itself is not counted.
- R2: A channel samples its input only on a sample tick, using the level after two flops of synchronization. A falling edge is a tick whose sampled level is 0 while the level sampled on the previous tick was 1. The stored previous level updates on every tick in every state, so the fastest input resolved has a period of two ticks.
- R3: The gate closes on the 2^GATE_W-th tick after the opening edge, when the gate timer rolls over from all ones. A falling edge on that closing tick is still counted.
- R4: Each counted edge increments the count. On the same tick, the time output is loaded with the number of ticks elapsed since the opening edge, including the current tick.
- R5: The count and the time both saturate at 2^CNT_W-1. The overflow output is 1 in Done if the count or a captured time would have exceeded that value.
- R6: The done output is a pulse of exactly one clock. It is high in the clock after the tick edge that causes close or timeout. Count and time then hold until the next start.
- R7: In Done, the no-signal output is 1 when the count is zero. The valid output is 1 when the count is nonzero and there was no overflow. Outside Done, both are 0.
- R8: If no falling edge arrives within 2^GATE_W ticks after start, the channel takes timeout. Its done pulse follows the 2^GATE_W-th tick, with the no-signal output set.
- R9: The channels share the start and the tick but are otherwise independent. Each one opens, closes and reports on its own input.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-clock pulse that arms every channel |
| tick_i | input | 1 | Sample-tick enable, one clock wide |
| sig_i | input | NUM_CH | Raw square-wave inputs, one bit per channel |
| cnt_o | output | NUM_CH*CNT_W | Falling-edge count per channel, channel 0 in the low bits |
| time_o | output | NUM_CH*CNT_W | Ticks from the opening edge to the last counted edge, per channel |
| done_o | output | NUM_CH | One-clock pulse when a channel finishes |
| valid_o | output | NUM_CH | Result usable for division |
| nosig_o | output | NUM_CH | Finished with a count of zero |
| ovf_o | output | NUM_CH | Count or captured time saturated |

## Verification
An input level reaches the edge detector two clocks after it changes. The bench therefore changes the inputs three clocks before the clock on which the tick is sampled. It treats that tick edge as the moment the level is seen. Done, no-signal, valid, overflow and the final count and time all settle on that same tick edge. The bench samples them on the next falling clock edge, and compares each one with its own tick-by-tick model of the requirements. The arming window and the one-clock done pulse are checked at exact tick and clock positions.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_ARM  = 2'd1,
        CH_GATE = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

endpackage

// File: rtl/rfc_sync.sv
module rfc_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic meta_q;
            logic stable_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q   <= 1'b0;
                    stable_q <= 1'b0;
                end else begin
                    meta_q   <= async_i[b];
                    stable_q <= meta_q;
                end
            end

            assign sync_o[b] = stable_q;
        end
    endgenerate

endmodule

// File: rtl/rfc_sat_counter.sv
module rfc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] val_o,
    output logic [W-1:0] nxt_o
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] val_q;

    // The next value holds at the ceiling instead of wrapping.
    assign nxt_o = (val_q == MAXV) ? val_q : val_q + ONE;
    assign val_o = val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (inc_i) begin
            val_q <= nxt_o;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && val_q == MAXV) |=> (val_q == MAXV)); // R5
    AST_SAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && val_q != MAXV) |=> (val_q == $past(val_q) + ONE)); // R4
    AST_SAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_q == '0)); // R1

endmodule

// File: rtl/rfc_channel.sv
module rfc_channel
    import rfc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int GATE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             lvl_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] time_o,
    output logic             done_o,
    output logic             valid_o,
    output logic             nosig_o,
    output logic             ovf_o
);

    localparam logic [GATE_W-1:0] GATE_ONE = GATE_W'(1);

    ch_state_e         state_q, state_d;
    logic              prev_q;
    logic              fall;
    logic [GATE_W-1:0] gate_q;
    logic              gate_last;
    logic              open_edge;
    logic              cnt_clr, cnt_inc, ts_inc;
    logic [CNT_W-1:0]  cnt_val, cnt_nxt, ts_val, ts_nxt;
    logic [CNT_W-1:0]  cap_q;
    logic              ovf_q;
    logic              done_q;
    logic              in_done;

    // Edge detection on sample ticks only.
    assign fall = tick_i & prev_q & ~lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else if (tick_i) begin
            prev_q <= lvl_i;
        end
    end

    // Gate timer: times the arming window, then the gate.
    assign gate_last = &gate_q;
    assign open_edge = (state_q == CH_ARM) & fall & ~start_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (start_i || open_edge) begin
            gate_q <= '0;
        end else if (tick_i && (state_q == CH_ARM || state_q == CH_GATE)) begin
            gate_q <= gate_q + GATE_ONE;
        end
    end

    // Edge count and timestamp.
    assign cnt_clr = start_i | open_edge;
    assign cnt_inc = (state_q == CH_GATE) & fall & ~start_i;
    assign ts_inc  = (state_q == CH_GATE) & tick_i & ~start_i;

    rfc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .val_o (cnt_val),
        .nxt_o (cnt_nxt)
    );

    rfc_sat_counter #(.W(CNT_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (ts_inc),
        .val_o (ts_val),
        .nxt_o (ts_nxt)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: arm, open, timeout, close.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start_i) state_d = CH_ARM;
            end
            CH_ARM: begin
                if (start_i)                   state_d = CH_ARM;
                else if (fall)                 state_d = CH_GATE;
                else if (tick_i && gate_last)  state_d = CH_DONE;
            end
            CH_GATE: begin
                if (start_i)                   state_d = CH_ARM;
                else if (tick_i && gate_last)  state_d = CH_DONE;
            end
            CH_DONE: begin
                if (start_i) state_d = CH_ARM;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Registered outputs: done pulse, capture, overflow.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            cap_q  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= (state_d == CH_DONE) && (state_q != CH_DONE);
            if (cnt_clr) begin
                cap_q <= '0;
                ovf_q <= 1'b0;
            end else if (cnt_inc) begin
                cap_q <= ts_nxt;
                ovf_q <= ovf_q | (cnt_nxt == cnt_val) | (ts_nxt == ts_val);
            end
        end
    end

    assign in_done = (state_q == CH_DONE);
    assign cnt_o   = cnt_val;
    assign time_o  = cap_q;
    assign done_o  = done_q;
    assign ovf_o   = in_done & ovf_q;
    assign nosig_o = in_done & (cnt_val == '0);
    assign valid_o = in_done & (cnt_val != '0) & ~ovf_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_done && !start_i) |=> ($stable(cnt_val) && $stable(cap_q))); // R6
    AST_NO_COUNT_ARMING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARM) |-> (cnt_val == '0)); // R1
    AST_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        open_edge |=> (state_q == CH_GATE && gate_q == '0 && ts_val == '0)); // R3
    AST_TIMEOUT_NOSIG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARM && !start_i && !fall && tick_i && gate_last) |=> (nosig_o && done_q)); // R8
    AST_CAP_BEHIND_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_GATE) |-> (cap_q <= ts_val)); // R4
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && nosig_o)); // R7

endmodule

// File: rtl/recip_freq_counter.sv
module recip_freq_counter #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int GATE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    tick_i,
    input  logic [NUM_CH-1:0]       sig_i,
    output logic [NUM_CH*CNT_W-1:0] cnt_o,
    output logic [NUM_CH*CNT_W-1:0] time_o,
    output logic [NUM_CH-1:0]       done_o,
    output logic [NUM_CH-1:0]       valid_o,
    output logic [NUM_CH-1:0]       nosig_o,
    output logic [NUM_CH-1:0]       ovf_o
);

    logic [NUM_CH-1:0] lvl;

    rfc_sync #(.WIDTH(NUM_CH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sig_i),
        .sync_o  (lvl)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            rfc_channel #(.CNT_W(CNT_W), .GATE_W(GATE_W)) u_channel (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (start_i),
                .tick_i  (tick_i),
                .lvl_i   (lvl[ch]),
                .cnt_o   (cnt_o[ch*CNT_W +: CNT_W]),
                .time_o  (time_o[ch*CNT_W +: CNT_W]),
                .done_o  (done_o[ch]),
                .valid_o (valid_o[ch]),
                .nosig_o (nosig_o[ch]),
                .ovf_o   (ovf_o[ch])
            );
        end
    endgenerate

endmodule

// File: tb/recip_freq_counter_bench.sv
module recip_freq_counter_bench;

    localparam int GW = 6;
    localparam int GM = (1 << GW) - 1;
    localparam int STEPS = 150;

    typedef struct packed {
        int pa;
        int pb;
        int fa;
        int fb;
    } vec_t;

    // Period in ticks (0 = flat, level taken from the phase bit) and phase.
    localparam vec_t VECS [6] = '{
        '{4, 10, 0, 3},   // R9 unrelated rates
        '{6, 2, 1, 0},    // R2 fastest input on channel 1, narrow overflow R5
        '{0, 8, 1, 2},    // R8 flat high on channel 0
        '{20, 0, 5, 0},   // R8 flat low on channel 1
        '{70, 3, 0, 1},   // R7 one edge only on channel 0, odd period on 1
        '{2, 5, 1, 4}     // R5 saturation in the narrow instance
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tick = 1'b0;
    logic [1:0]  sig = 2'b00;

    logic [31:0] w_cnt, w_time;
    logic [1:0]  w_done, w_valid, w_nosig, w_ovf;
    logic [7:0]  n_cnt, n_time;
    logic [1:0]  n_done, n_valid, n_nosig, n_ovf;

    int checks = 0;
    int failures = 0;
    int cur_pa, cur_pb, cur_fa, cur_fb;

    // Model state, index = instance*2 + channel.
    int m_st [4];
    int m_tmr [4];
    int m_ts [4];
    int m_cnt [4];
    int m_cap [4];
    bit m_ovf [4];
    bit m_prev [4];
    bit m_dev [4];
    int derr [4];

    always #2 clk = ~clk;

    recip_freq_counter #(.NUM_CH(2), .CNT_W(16), .GATE_W(GW)) u_recip_freq_counter (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .sig_i(sig),
        .cnt_o(w_cnt), .time_o(w_time), .done_o(w_done), .valid_o(w_valid),
        .nosig_o(w_nosig), .ovf_o(w_ovf)
    );

    recip_freq_counter #(.NUM_CH(2), .CNT_W(4), .GATE_W(GW)) u_recip_freq_counter_narrow (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .sig_i(sig),
        .cnt_o(n_cnt), .time_o(n_time), .done_o(n_done), .valid_o(n_valid),
        .nosig_o(n_nosig), .ovf_o(n_ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit lvl_of(input int k, input int p, input int ph);
        if (p == 0) return ph[0];
        return ((k + ph) % p) < (p / 2);
    endfunction

    function automatic int cmax(input int i);
        return (i < 2) ? 65535 : 15;
    endfunction

    function automatic int a_cnt(input int i);
        return (i < 2) ? int'(w_cnt[(i%2)*16 +: 16]) : int'(n_cnt[(i%2)*4 +: 4]);
    endfunction
    function automatic int a_time(input int i);
        return (i < 2) ? int'(w_time[(i%2)*16 +: 16]) : int'(n_time[(i%2)*4 +: 4]);
    endfunction
    function automatic bit a_done(input int i);
        return (i < 2) ? w_done[i%2] : n_done[i%2];
    endfunction
    function automatic bit a_valid(input int i);
        return (i < 2) ? w_valid[i%2] : n_valid[i%2];
    endfunction
    function automatic bit a_nosig(input int i);
        return (i < 2) ? w_nosig[i%2] : n_nosig[i%2];
    endfunction
    function automatic bit a_ovf(input int i);
        return (i < 2) ? w_ovf[i%2] : n_ovf[i%2];
    endfunction

    task automatic model_start();
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 1; m_tmr[i] = 0; m_ts[i] = 0;
            m_cnt[i] = 0; m_cap[i] = 0; m_ovf[i] = 1'b0;
        end
    endtask

    task automatic model_step(input bit la, input bit lb);
        for (int i = 0; i < 4; i++) begin
            bit lv;
            bit fl;
            lv = (i % 2 == 0) ? la : lb;
            fl = m_prev[i] && !lv;
            m_dev[i] = 1'b0;
            if (m_st[i] == 1) begin
                if (fl) begin
                    m_st[i] = 2; m_tmr[i] = 0; m_ts[i] = 0;
                    m_cnt[i] = 0; m_cap[i] = 0; m_ovf[i] = 1'b0;
                end else if (m_tmr[i] == GM) begin
                    m_st[i] = 3; m_dev[i] = 1'b1;
                end else begin
                    m_tmr[i]++;
                end
            end else if (m_st[i] == 2) begin
                m_ts[i]++;
                if (fl) begin
                    m_cnt[i]++;
                    if (m_cnt[i] > cmax(i)) begin m_cnt[i] = cmax(i); m_ovf[i] = 1'b1; end
                    if (m_ts[i] > cmax(i)) begin m_cap[i] = cmax(i); m_ovf[i] = 1'b1; end
                    else m_cap[i] = m_ts[i];
                end
                if (m_tmr[i] == GM) begin
                    m_st[i] = 3; m_dev[i] = 1'b1;
                end else begin
                    m_tmr[i]++;
                end
            end
            m_prev[i] = lv;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        model_start();
    endtask

    // Inputs change three clocks before the tick edge; sampled at the next falling edge.
    task automatic do_step(input bit la, input bit lb);
        @(negedge clk); sig = {lb, la}; tick = 1'b0;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        model_step(la, lb);
        for (int i = 0; i < 4; i++) if (a_done(i) != m_dev[i]) derr[i]++;
    endtask

    task automatic run_steps(input int n);
        for (int k = 0; k < n; k++)
            do_step(lvl_of(k, cur_pa, cur_fa), lvl_of(k, cur_pb, cur_fb));
    endtask

    task automatic check_results(input string tag);
        for (int i = 0; i < 4; i++) begin
            bit dn;
            dn = (m_st[i] == 3);
            chk(derr[i] == 0, "R3/R6", {tag, " done pulse timing"}, derr[i], 0);
            chk(a_cnt(i) == m_cnt[i], "R4/R5", {tag, " count"}, a_cnt(i), m_cnt[i]);
            chk(a_time(i) == m_cap[i], "R4/R5", {tag, " time"}, a_time(i), m_cap[i]);
            chk(a_valid(i) == (dn && m_cnt[i] != 0 && !m_ovf[i]), "R7", {tag, " valid"},
                a_valid(i), dn && m_cnt[i] != 0 && !m_ovf[i]);
            chk(a_nosig(i) == (dn && m_cnt[i] == 0), "R7", {tag, " nosig"},
                a_nosig(i), dn && m_cnt[i] == 0);
            chk(a_ovf(i) == (dn && m_ovf[i]), "R5", {tag, " overflow"}, a_ovf(i), dn && m_ovf[i]);
            derr[i] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 0; m_prev[i] = 1'b0; m_dev[i] = 1'b0; derr[i] = 0;
            m_cnt[i] = 0; m_cap[i] = 0; m_ovf[i] = 1'b0; m_tmr[i] = 0; m_ts[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk({w_done, w_valid, w_nosig, w_ovf} == 8'd0, "R10", "wide flags after reset",
            {w_done, w_valid, w_nosig, w_ovf}, 0);
        chk({w_cnt, w_time} == 64'd0, "R10", "wide count/time after reset", {w_cnt, w_time}, 0);
        chk({n_done, n_valid, n_nosig, n_ovf, n_cnt, n_time} == 24'd0, "R10",
            "narrow outputs after reset", {n_done, n_valid, n_nosig, n_ovf, n_cnt, n_time}, 0);

        // Table of stimulus; each run continues past done to show results hold (R6).
        for (int v = 0; v < 6; v++) begin
            cur_pa = VECS[v].pa; cur_pb = VECS[v].pb;
            cur_fa = VECS[v].fa; cur_fb = VECS[v].fb;
            pulse_start();
            run_steps(STEPS);
            check_results($sformatf("vector %0d", v));
        end

        // R1 restart in the middle of a gate
        cur_pa = 6; cur_pb = 4; cur_fa = 0; cur_fb = 1;
        pulse_start();
        run_steps(20);
        pulse_start();
        run_steps(STEPS);
        check_results("R1 restart");

        // R8 arming window: flat inputs, done exactly after tick 2^GW
        cur_pa = 0; cur_pb = 0; cur_fa = 1; cur_fb = 0;
        run_steps(2);
        pulse_start();
        run_steps(GM);
        chk({w_done, n_done} == 4'd0, "R8", "no done before window end", {w_done, n_done}, 0);
        do_step(1'b1, 1'b0);
        chk({w_done, n_done} == 4'hF, "R8", "done on last window tick", {w_done, n_done}, 15);
        chk({w_nosig, n_nosig} == 4'hF, "R8", "nosig on timeout", {w_nosig, n_nosig}, 15);
        @(negedge clk);
        chk({w_done, n_done} == 4'd0, "R6", "done lasts one clock", {w_done, n_done}, 0);
        check_results("R8 timeout");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule